// File: doc/BRIEF.md
# Two-Level Nested Interrupt Arbiter

This block collects six interrupt requests for a small 8-bit controller core and picks the one the core should take next. The six sources are two external pins, the overflows of timer 0 and timer 1, the serial port (receive or transmit) and timer 2. A priority register places each source in the high or the low level. A handler in service can only be pre-empted by a request from a strictly higher level. Requests of the same level are resolved by a fixed polling order.

The block keeps one in-service bit per level. When the core vectors, it pulses `vec_ack`. The block then marks the granted level as in service and clears the flags that hardware owns: the two timer overflow flags and the external edge flags. The serial and timer 2 requests arrive as levels that software clears somewhere else. A `reti` pulse ends the handler of the highest active level.

The external pins are sampled on a machine-cycle strobe. Each pin is either edge-triggered or level-triggered.

Top module: `intr_prio_ctrl`

## Requirements
- R1: After reset, `irq_req` is 0, `in_svc` is 0, and the edge and timer flags are all 0.
- R2: Source indices are ext0=0, tmr0=1, ext1=2, tmr1=3, serial=4, tmr2=5. `prio_reg` bit k (k=0..4) puts source k in the high level when it is 1. Bits 7..5 have no effect. Timer 2 is always in the low level.
- R3: Within one level, the pending source with the lowest index wins, and its index appears on `irq_src`.
- R4: When nothing is in service, any pending high-level source wins over every low-level source, and `irq_hi` is 1 for it.
- R5: While the low level is in service, only high-level requests raise `irq_req`. While the high level is in service, `irq_req` stays 0.
- R6: A source takes part only when `glb_en` is 1 and its `src_en` bit is 1.
- R7: When `ext_edge_mode[i]` is 1, a strobe sample of 0 that follows a strobe sample of 1 sets `ext_flag[i]`. The flag then stays set until the core vectors to that source. Pin changes between strobes do nothing until the next strobe.
- R8: When `ext_edge_mode[i]` is 0, the request for external source i follows the last strobe sample being 0. It is not latched, and vectoring does not clear it.
- R9: A `vec_ack` while `irq_req` is 1 clears the timer flag or edge flag of the granted source. A new overflow pulse in the same cycle wins over the clear. The serial and timer 2 requests are left alone.
- R10: A `reti` pulse clears the high in-service bit if that bit is set. Otherwise it clears the low in-service bit.
- R11: A `vec_ack` while `irq_req` is 1 sets the in-service bit of the granted level, given by `irq_hi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_stb | input | 1 | Machine-cycle strobe that samples the external pins |
| ext_pin_n | input | 2 | External interrupt pins, active low |
| ext_edge_mode | input | 2 | 1 = falling edge, 0 = low level, one bit per pin |
| tmr_ovf | input | 2 | Overflow pulses from timer 0 and timer 1 |
| ser_pend | input | 1 | Serial receive or transmit request, as a level |
| tmr2_pend | input | 1 | Timer 2 request, as a level |
| glb_en | input | 1 | Global enable |
| src_en | input | 6 | Enable for each source, by index |
| prio_reg | input | 8 | Priority level register |
| vec_ack | input | 1 | Core vectors to the offered source |
| reti | input | 1 | Return from interrupt |
| irq_req | output | 1 | A source is offered to the core |
| irq_src | output | 3 | Index of the offered source |
| irq_hi | output | 1 | The offered source is in the high level |
| in_svc | output | 2 | In-service bits: bit 1 high level, bit 0 low level |
| ext_flag | output | 2 | Latched external edge flags |
| tmr_flag | output | 2 | Latched timer 0 and timer 1 overflow flags |

## Verification
Two functions can act in the same cycle: a timer overflow setting its flag, and a vector to that same timer clearing it. The bench provokes this by pulsing `tmr_ovf[0]` in the very cycle that `vec_ack` grants timer 0. It then requires the flag to remain set and the high in-service bit to be taken. It also checks that, after the matching `reti`, the surviving flag is offered again. A second sweep covers arbitration: every combination of the six pending sources is tried under every setting of the five priority bits, with junk in the reserved bits, and the offered index and level are compared with a winner computed arithmetically in the bench.

// File: rtl/intr_prio_ctrl.sv
module intr_prio_ctrl #(
  parameter int NSRC = 6,
  parameter int NEXT = 2,
  parameter int NPRB = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_stb,
  input  logic [NEXT-1:0]   ext_pin_n,
  input  logic [NEXT-1:0]   ext_edge_mode,
  input  logic [1:0]        tmr_ovf,
  input  logic              ser_pend,
  input  logic              tmr2_pend,
  input  logic              glb_en,
  input  logic [NSRC-1:0]   src_en,
  input  logic [7:0]        prio_reg,
  input  logic              vec_ack,
  input  logic              reti,
  output logic              irq_req,
  output logic [$clog2(NSRC)-1:0] irq_src,
  output logic              irq_hi,
  output logic [1:0]        in_svc,
  output logic [NEXT-1:0]   ext_flag,
  output logic [1:0]        tmr_flag
);
  localparam int IW = $clog2(NSRC);

  logic [NEXT-1:0] samp;
  logic [NEXT-1:0] ext_req;
  logic [NSRC-1:0] pend, cand, hi_mask, hi_c, lo_c;
  logic            grant;

  assign grant = vec_ack & irq_req;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) samp <= '1;
    else if (cyc_stb) samp <= ext_pin_n;

  for (genvar i = 0; i < NEXT; i++) begin : g_ext
    logic fall;
    assign fall = cyc_stb & samp[i] & ~ext_pin_n[i] & ext_edge_mode[i];
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) ext_flag[i] <= 1'b0;
      else if (!ext_edge_mode[i]) ext_flag[i] <= 1'b0;
      else if (fall) ext_flag[i] <= 1'b1;
      else if (grant && irq_src == IW'(2 * i)) ext_flag[i] <= 1'b0;
    assign ext_req[i] = ext_edge_mode[i] ? ext_flag[i] : ~samp[i];
  end

  for (genvar t = 0; t < 2; t++) begin : g_tmr
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) tmr_flag[t] <= 1'b0;
      else if (tmr_ovf[t]) tmr_flag[t] <= 1'b1;
      else if (grant && irq_src == IW'(2 * t + 1)) tmr_flag[t] <= 1'b0;
  end

  assign pend    = {tmr2_pend, ser_pend, tmr_flag[1], ext_req[1], tmr_flag[0], ext_req[0]};
  assign cand    = pend & src_en & {NSRC{glb_en}};
  assign hi_mask = {{(NSRC-NPRB){1'b0}}, prio_reg[NPRB-1:0]};
  assign hi_c    = cand & hi_mask;
  assign lo_c    = cand & ~hi_mask;

  function automatic logic [IW-1:0] first_set(input logic [NSRC-1:0] v);
    logic [IW-1:0] f;
    f = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (v[i]) f = IW'(i);
    return f;
  endfunction

  always_comb begin
    irq_req = 1'b0;
    irq_hi  = 1'b0;
    irq_src = '0;
    if (!in_svc[1] && |hi_c) begin
      irq_req = 1'b1;
      irq_hi  = 1'b1;
      irq_src = first_set(hi_c);
    end else if (in_svc == 2'b00 && |lo_c) begin
      irq_req = 1'b1;
      irq_src = first_set(lo_c);
    end
  end

  logic [1:0] svc_clr, svc_set;
  assign svc_clr = !reti ? 2'b00 : (in_svc[1] ? 2'b10 : 2'b01);
  assign svc_set = !grant ? 2'b00 : (irq_hi ? 2'b10 : 2'b01);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) in_svc <= 2'b00;
    else in_svc <= (in_svc & ~svc_clr) | svc_set;

  a_r5_high_blocks_all: assert property (@(posedge clk) disable iff (!rst_n)
    in_svc[1] |-> !irq_req);
  a_r5_low_only_high: assert property (@(posedge clk) disable iff (!rst_n)
    (in_svc[0] && irq_req) |-> irq_hi);
  a_r6_global_off: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> !irq_req);
  a_r11_grant_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack && irq_req && irq_hi) |=> in_svc[1]);
  a_r9_tmr0_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack && irq_req && irq_src == IW'(1) && !tmr_ovf[0]) |=> !tmr_flag[0]);
  a_r10_reti_high: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && in_svc[1]) |=> !in_svc[1]);
  a_r10_reti_low: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && in_svc == 2'b01 && !vec_ack) |=> in_svc == 2'b00);
  a_r7_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_flag[0] && ext_edge_mode[0] && !vec_ack) |=> ext_flag[0]);
endmodule

// File: tb/intr_prio_ctrl_tb.sv
module intr_prio_ctrl_tb;
  logic clk = 0, rst_n = 0, cyc_stb = 1;
  logic [1:0] ext_pin_n = 2'b11, ext_edge_mode = 2'b00, tmr_ovf = 2'b00;
  logic ser_pend = 0, tmr2_pend = 0, glb_en = 1, vec_ack = 0, reti = 0;
  logic [5:0] src_en = '1;
  logic [7:0] prio_reg = '0;
  logic irq_req, irq_hi;
  logic [2:0] irq_src;
  logic [1:0] in_svc, ext_flag, tmr_flag;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  intr_prio_ctrl u_dut (.clk, .rst_n, .cyc_stb, .ext_pin_n, .ext_edge_mode, .tmr_ovf,
    .ser_pend, .tmr2_pend, .glb_en, .src_en, .prio_reg, .vec_ack, .reti,
    .irq_req, .irq_src, .irq_hi, .in_svc, .ext_flag, .tmr_flag);

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 0; ext_pin_n = 2'b11; tmr_ovf = 0; ser_pend = 0; tmr2_pend = 0;
    vec_ack = 0; reti = 0; cyc_stb = 1; ext_edge_mode = 0;
    tick; rst_n = 1;
  endtask

  task automatic pulse_ack;
    vec_ack = 1; tick; vec_ack = 0;
  endtask

  task automatic pulse_reti;
    reti = 1; tick; reti = 0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset;
    // R1 reset state
    chk("R1 irq_req", irq_req, 0);
    chk("R1 in_svc", in_svc, 0);
    chk("R1 flags", {ext_flag, tmr_flag}, 0);

    // R2 R3 R4 sweep: all pending sets by all priority settings
    for (int p = 0; p < 64; p++) begin
      for (int q = 0; q < 32; q++) begin
        int e_hi, e_lo, e_src, e_h;
        logic [5:0] hm;
        do_reset;
        prio_reg = {p[2:0], q[4:0]};
        ext_pin_n = {~p[2], ~p[0]};
        tmr_ovf = {p[3], p[1]};
        ser_pend = p[4]; tmr2_pend = p[5];
        tick; tmr_ovf = 0;
        hm = {1'b0, q[4:0]};
        e_hi = -1; e_lo = -1;
        for (int k = 5; k >= 0; k--) begin
          if (p[k] && hm[k]) e_hi = k;
          if (p[k] && !hm[k]) e_lo = k;
        end
        e_h = (e_hi >= 0);
        e_src = e_h ? e_hi : e_lo;
        chk("R4 irq_req", irq_req, p != 0);
        if (p != 0) begin
          chk("R2 irq_hi", irq_hi, e_h);
          chk("R3 irq_src", irq_src, e_src);
        end
      end
    end

    // R6 enables
    do_reset; prio_reg = 0; ser_pend = 1; glb_en = 0; tick;
    chk("R6 global off", irq_req, 0);
    glb_en = 1; src_en[4] = 0; tick;
    chk("R6 source off", irq_req, 0);
    src_en = '1; tick;
    chk("R6 both on", irq_req, 1);

    // R5 R9 R10 R11 nesting and same-cycle set/clear
    chk("R3 serial offered", irq_src, 4);
    pulse_ack;
    chk("R11 low in service", in_svc, 1);
    chk("R5 same level blocked", irq_req, 0);
    prio_reg = 8'h02; tmr_ovf[0] = 1; tick; tmr_ovf[0] = 0;
    chk("R5 high preempts", irq_req, 1);
    chk("R5 high src", irq_src, 1);
    chk("R4 high level", irq_hi, 1);
    vec_ack = 1; tmr_ovf[0] = 1; tick; vec_ack = 0; tmr_ovf[0] = 0;
    chk("R9 set wins over clear", tmr_flag[0], 1);
    chk("R11 high in service", in_svc, 3);
    chk("R5 high blocks all", irq_req, 0);
    pulse_reti;
    chk("R10 high cleared first", in_svc, 1);
    chk("R5 flag offered again", irq_src, 1);
    pulse_ack;
    chk("R9 tmr0 flag cleared", tmr_flag[0], 0);
    pulse_reti;
    chk("R10 back to low", in_svc, 1);
    chk("R5 low still blocked", irq_req, 0);
    pulse_reti;
    chk("R10 low cleared", in_svc, 0);
    chk("R9 serial untouched", irq_req, 1);
    chk("R9 serial src", irq_src, 4);

    // R7 edge mode
    do_reset; prio_reg = 0; ext_edge_mode = 2'b01; cyc_stb = 0;
    ext_pin_n[0] = 0; tick;
    chk("R7 no strobe no flag", ext_flag[0], 0);
    cyc_stb = 1; tick;
    chk("R7 edge sets flag", ext_flag[0], 1);
    ext_pin_n[0] = 1; tick; tick;
    chk("R7 flag held", ext_flag[0], 1);
    chk("R7 offered", irq_src, 0);
    pulse_ack;
    chk("R9 edge flag cleared", ext_flag[0], 0);
    chk("R9 no request left", irq_req, 0);
    pulse_reti;

    // R8 level mode
    do_reset; prio_reg = 0; ext_pin_n[1] = 0; tick;
    chk("R8 level request", irq_src, 2);
    pulse_ack; pulse_reti;
    chk("R8 not cleared by vector", irq_req, 1);
    chk("R8 no latch", ext_flag[1], 0);
    ext_pin_n[1] = 1; tick;
    chk("R8 follows pin", irq_req, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule